// File: doc/BRIEF.md
# Per-Lane Vector Funnel Shifter

This block shifts a vector of independent 32-bit lanes. In each lane, operand A forms the upper half and operand B the lower half of a 64-bit value. That value is shifted by the lane's own count, and one 32-bit window is returned. A right shift returns the low window. A left shift returns the high window.

Two control inputs apply to all lanes at once. One selects the direction. The other selects how out-of-range counts are handled: wrap (reduce modulo 32) or clamp (saturate at 32). When A equals B, the right shift gives a rotate right. A rotate left is obtained by negating the count in wrap mode.

The result passes through an optional output register, which is enabled by default. A valid pulse on the input appears on the output one cycle later.

Top module: `vec_funnel_shift`

## Requirements
- R1: With `shiftLeft`=0, each lane's result is the low 32 bits of the 64-bit value {A,B} shifted right by the effective count.
- R2: With `shiftLeft`=1, each lane's result is the high 32 bits of {A,B} shifted left by the effective count.
- R3: Lanes are independent. Lane i uses bits [32*i +: 32] of `opA`, `opB` and `result`, and bits [8*i +: 8] of `shiftCnt`. No bit crosses a lane boundary.
- R4: With `clampMode`=0 (wrap), the effective count is the 8-bit count modulo 32, which is its low 5 bits.
- R5: With `clampMode`=1 (clamp), any count of 32 to 255 acts as exactly 32. A right shift then returns A and a left shift returns B.
- R6: A count of zero returns B for a right shift and A for a left shift, in both modes.
- R7: When A equals B, a right shift in wrap mode gives a rotate right of that value. A right shift by (256 - n) mod 256 gives a rotate left by n mod 32.
- R8: When `validIn` is high at a clock edge, all lanes are captured together. `validOut` is high in the following cycle and low after any cycle with `validIn` low. A synchronous active-high `rst` clears `validOut`.
- R9: While `validIn` is low, changes on the data, count and control inputs leave `result` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| validIn | input | 1 | Input vector valid, captures the result |
| shiftLeft | input | 1 | 1 = left funnel shift, 0 = right |
| clampMode | input | 1 | 1 = clamp counts at 32, 0 = wrap modulo 32 |
| opA | input | NumLanes*32 | Upper halves, one per lane |
| opB | input | NumLanes*32 | Lower halves, one per lane |
| shiftCnt | input | NumLanes*8 | Per-lane shift counts |
| result | output | NumLanes*32 | Per-lane shifted windows |
| validOut | output | 1 | Result valid |

## Verification
Directed vectors give the counts 0, 1, 31, 32, 33 and 255 in every direction and mode combination. Each lane is given a different count, so a lane that picks up a neighbour's count or bits gives a wrong result. Counts 32, 33 and 255 separate wrap from clamp handling. Counts 0 and 31 expose off-by-one errors in the window selection.

Equal A and B operands are compared against a separately written rotate model, both for plain counts and for negated counts. Random data and counts cover the general case. Holding `validIn` low while the inputs change shows whether the output register captures only when asked.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  typedef struct packed {
    logic capture;
    logic shiftLeft;
    logic clampCnt;
  } vfsCtrl_t;
endpackage

// File: rtl/vfs_ctrl.sv
module vfs_ctrl
  import vfs_pkg::*;
#(
  parameter bit UseOutReg = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     validIn,
  input  logic     shiftLeft,
  input  logic     clampMode,
  output vfsCtrl_t ctrl,
  output logic     validOut
);
  always_comb begin
    ctrl.capture   = validIn;
    ctrl.shiftLeft = shiftLeft;
    ctrl.clampCnt  = clampMode;
  end

  generate
    if (UseOutReg) begin : g_reg
      logic validQ;
      always_ff @(posedge clk) begin
        if (rst) validQ <= 1'b0;
        else     validQ <= validIn;
      end
      assign validOut = validQ;

      assert_valid_follow_R8: assert property (@(posedge clk) disable iff (rst)
        validIn |=> validOut);
      assert_valid_drop_R8: assert property (@(posedge clk) disable iff (rst)
        !validIn |=> !validOut);
    end else begin : g_comb
      assign validOut = validIn;
    end
  endgenerate
endmodule

// File: rtl/vfs_datapath.sv
module vfs_datapath
  import vfs_pkg::*;
#(
  parameter int NumLanes   = 4,
  parameter int LaneWidth  = 32,
  parameter int CountWidth = 8,
  parameter bit UseOutReg  = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  vfsCtrl_t                        ctrl,
  input  logic [NumLanes*LaneWidth-1:0]   opA,
  input  logic [NumLanes*LaneWidth-1:0]   opB,
  input  logic [NumLanes*CountWidth-1:0]  shiftCnt,
  output logic [NumLanes*LaneWidth-1:0]   result
);
  localparam int ShW     = $clog2(LaneWidth) + 1;
  localparam int ModW    = ShW - 1;
  localparam int JoinW   = 2 * LaneWidth;
  localparam int VecW    = NumLanes * LaneWidth;

  logic [VecW-1:0] laneResAll;

  generate
    for (genvar i = 0; i < NumLanes; i++) begin : g_lane
      logic [LaneWidth-1:0]  laneA, laneB, laneRes;
      logic [CountWidth-1:0] cnt;
      logic [ShW-1:0]        effCnt;
      logic [JoinW-1:0]      joined, rightShifted, leftShifted;

      assign laneA  = opA[i*LaneWidth +: LaneWidth];
      assign laneB  = opB[i*LaneWidth +: LaneWidth];
      assign cnt    = shiftCnt[i*CountWidth +: CountWidth];
      assign joined = {laneA, laneB};

      always_comb begin
        if (ctrl.clampCnt) begin
          if (cnt >= CountWidth'(LaneWidth)) effCnt = ShW'(LaneWidth);
          else                               effCnt = cnt[ShW-1:0];
        end else begin
          effCnt = {1'b0, cnt[ModW-1:0]};
        end
      end

      assign rightShifted = joined >> effCnt;
      assign leftShifted  = joined << effCnt;
      assign laneRes = ctrl.shiftLeft ? leftShifted[JoinW-1:LaneWidth]
                                      : rightShifted[LaneWidth-1:0];
      assign laneResAll[i*LaneWidth +: LaneWidth] = laneRes;

      assert_clamp_right_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.clampCnt && !ctrl.shiftLeft && cnt >= CountWidth'(LaneWidth))
          |-> laneRes == laneA);
      assert_clamp_left_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.clampCnt && ctrl.shiftLeft && cnt >= CountWidth'(LaneWidth))
          |-> laneRes == laneB);
      assert_zero_right_R6: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.shiftLeft && cnt == '0) |-> laneRes == laneB);
      assert_zero_left_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl.shiftLeft && cnt == '0) |-> laneRes == laneA);
    end

    if (UseOutReg) begin : g_oreg
      logic [VecW-1:0] resultQ;
      always_ff @(posedge clk) begin
        if (ctrl.capture) resultQ <= laneResAll;
      end
      assign result = resultQ;

      assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !ctrl.capture |=> $stable(result));
      assert_capture_R8: assert property (@(posedge clk) disable iff (rst)
        ctrl.capture |=> result == $past(laneResAll));
    end else begin : g_ocomb
      assign result = laneResAll;
    end
  endgenerate
endmodule

// File: rtl/vec_funnel_shift.sv
module vec_funnel_shift
  import vfs_pkg::*;
#(
  parameter int NumLanes   = 4,
  parameter int LaneWidth  = 32,
  parameter int CountWidth = 8,
  parameter bit UseOutReg  = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           validIn,
  input  logic                           shiftLeft,
  input  logic                           clampMode,
  input  logic [NumLanes*LaneWidth-1:0]  opA,
  input  logic [NumLanes*LaneWidth-1:0]  opB,
  input  logic [NumLanes*CountWidth-1:0] shiftCnt,
  output logic [NumLanes*LaneWidth-1:0]  result,
  output logic                           validOut
);
  vfsCtrl_t ctrl;

  vfs_ctrl #(.UseOutReg(UseOutReg)) ctrl_i (
    .clk(clk), .rst(rst), .validIn(validIn), .shiftLeft(shiftLeft),
    .clampMode(clampMode), .ctrl(ctrl), .validOut(validOut)
  );

  vfs_datapath #(
    .NumLanes(NumLanes), .LaneWidth(LaneWidth),
    .CountWidth(CountWidth), .UseOutReg(UseOutReg)
  ) dp_i (
    .clk(clk), .rst(rst), .ctrl(ctrl), .opA(opA), .opB(opB),
    .shiftCnt(shiftCnt), .result(result)
  );
endmodule

// File: tb/vec_funnel_shift_tb_top.sv
`timescale 1ns/1ps
module vec_funnel_shift_tb_top;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic validIn = 1'b0, shiftLeft = 1'b0, clampMode = 1'b0;
  logic [NL*32-1:0] opA = '0, opB = '0;
  logic [NL*8-1:0]  shiftCnt = '0;
  logic [NL*32-1:0] result;
  logic validOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  vec_funnel_shift dut_i (
    .clk(clk), .rst(rst), .validIn(validIn), .shiftLeft(shiftLeft),
    .clampMode(clampMode), .opA(opA), .opB(opB), .shiftCnt(shiftCnt),
    .result(result), .validOut(validOut)
  );

  function automatic logic [31:0] refLane(logic [31:0] a, logic [31:0] b,
                                          logic [7:0] c, logic left, logic clamp);
    int n;
    logic [63:0] j;
    if (clamp) n = (c >= 8'd32) ? 32 : int'(c);
    else       n = int'(c) % 32;
    j = {a, b};
    if (left) begin
      j = j << n;
      return j[63:32];
    end
    j = j >> n;
    return j[31:0];
  endfunction

  function automatic logic [31:0] rotr(logic [31:0] x, int n);
    int m = n % 32;
    if (m == 0) return x;
    return (x >> m) | (x << (32 - m));
  endfunction

  function automatic logic [31:0] rotl(logic [31:0] x, int n);
    int m = n % 32;
    if (m == 0) return x;
    return (x << m) | (x >> (32 - m));
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [NL*32-1:0] a, logic [NL*32-1:0] b,
                       logic [NL*8-1:0] c, logic left, logic clamp);
    @(negedge clk);
    opA = a; opB = b; shiftCnt = c; shiftLeft = left; clampMode = clamp;
    validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
    check("R8 validOut", {31'd0, validOut}, 32'd1);
  endtask

  task automatic checkLanes(string tag, logic [NL*32-1:0] a, logic [NL*32-1:0] b,
                            logic [NL*8-1:0] c, logic left, logic clamp);
    for (int i = 0; i < NL; i++)
      check(tag, result[i*32 +: 32],
            refLane(a[i*32 +: 32], b[i*32 +: 32], c[i*8 +: 8], left, clamp));
  endtask

  function automatic logic [NL*32-1:0] rndVec();
    logic [NL*32-1:0] v;
    for (int i = 0; i < NL; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    #3_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NL*32-1:0] a, b, held;
    logic [NL*8-1:0] c;
    int dirCnt[6] = '{0, 1, 31, 32, 33, 255};
    void'($urandom(32'h5eed_2024));

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset validOut", {31'd0, validOut}, 32'd0);
    rst = 1'b0;

    // R1 R2 R3 R4 R5 R6: directed counts, each lane a different count
    for (int m = 0; m < 2; m++)
      for (int d = 0; d < 2; d++)
        for (int k = 0; k < 6; k++) begin
          a = rndVec(); b = rndVec();
          for (int i = 0; i < NL; i++) c[i*8 +: 8] = 8'(dirCnt[(k + i) % 6]);
          apply(a, b, c, d[0], m[0]);
          checkLanes(d[0] ? "R2/R3/R4/R5/R6 directed left" : "R1/R3/R4/R5/R6 directed right",
                     a, b, c, d[0], m[0]);
        end

    // R5 explicit clamp endpoints
    a = rndVec(); b = rndVec(); c = {NL{8'd200}};
    apply(a, b, c, 1'b0, 1'b1);
    for (int i = 0; i < NL; i++) check("R5 clamp right gives A", result[i*32 +: 32], a[i*32 +: 32]);
    apply(a, b, c, 1'b1, 1'b1);
    for (int i = 0; i < NL; i++) check("R5 clamp left gives B", result[i*32 +: 32], b[i*32 +: 32]);

    // R6 zero count
    c = '0;
    apply(a, b, c, 1'b0, 1'b1);
    for (int i = 0; i < NL; i++) check("R6 zero right gives B", result[i*32 +: 32], b[i*32 +: 32]);
    apply(a, b, c, 1'b1, 1'b0);
    for (int i = 0; i < NL; i++) check("R6 zero left gives A", result[i*32 +: 32], a[i*32 +: 32]);

    // R7 rotate right and rotate left via negated count
    for (int t = 0; t < 20; t++) begin
      a = rndVec();
      for (int i = 0; i < NL; i++) c[i*8 +: 8] = 8'($urandom);
      apply(a, a, c, 1'b0, 1'b0);
      for (int i = 0; i < NL; i++)
        check("R7 rotate right", result[i*32 +: 32], rotr(a[i*32 +: 32], int'(c[i*8 +: 8])));
      b = c;
      for (int i = 0; i < NL; i++) b[i*8 +: 8] = 8'(-c[i*8 +: 8]);
      apply(a, a, b[NL*8-1:0], 1'b0, 1'b0);
      for (int i = 0; i < NL; i++)
        check("R7 rotate left by negation", result[i*32 +: 32], rotl(a[i*32 +: 32], int'(c[i*8 +: 8])));
    end

    // R9 hold while validIn low
    held = result;
    @(negedge clk);
    opA = rndVec(); opB = rndVec(); shiftCnt = ~shiftCnt; shiftLeft = ~shiftLeft;
    clampMode = ~clampMode;
    @(negedge clk);
    check("R8 validOut low after idle", {31'd0, validOut}, 32'd0);
    for (int i = 0; i < NL; i++) check("R9 hold", result[i*32 +: 32], held[i*32 +: 32]);

    // R1 R2 R3 R4 R5 random
    for (int t = 0; t < 300; t++) begin
      logic left, clamp;
      a = rndVec(); b = rndVec();
      for (int i = 0; i < NL; i++) c[i*8 +: 8] = 8'($urandom);
      left = 1'($urandom); clamp = 1'($urandom);
      apply(a, b, c, left, clamp);
      checkLanes("R1/R2/R3/R4/R5 random", a, b, c, left, clamp);
    end

    // R8 reset clears validOut
    @(negedge clk);
    validIn = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R8 reset clears validOut", {31'd0, validOut}, 32'd0);
    rst = 1'b0; validIn = 1'b0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule